// File: doc/BRIEF.md
# Receive-Driven Character Timeout Counter

This block is a down-counter whose restarts come from the receive data path. A strobe marks each character moved into the receive holding register. That strobe stops the counter, reloads it from a 16-bit preload (an upper byte and a lower byte), and lets it count again. If no later character arrives before the count reaches zero, a counter-ready flag is set. Through a mask bit, the flag can become an interrupt request. Software can use this to learn that characters are waiting in the receive FIFO, or that the line has been idle for longer than the programmed interval.

The counter only advances on cycles where the counter-clock enable `ct_tick` is high. Byte commands arrive on a write strobe, and only the upper nibble of each command byte is decoded. Nibble 0xA turns timeout mode on and nibble 0xC turns it off. Nibbles 0x8 and 0x9 are the ordinary start and stop commands of plain counting. These two are refused while timeout mode is on.

Top module: `rx_char_timer`

## Requirements
- R1: In timeout mode, a character strobe takes effect at the first `ct_tick` edge at or after it. That edge stops the counter and loads the preload value N. The next tick edge restarts the count, and each later tick edge decrements by one. With `ct_tick` held high and the strobe sampled at edge E0, `ctr_ready` first reads 1 after edge E(N+1).
- R2: `ctr_ready` is set at the tick edge where the count goes from 1 to 0.
- R3: `irq_req` is high exactly when `ctr_ready` is high and `irq_mask` is high.
- R4: In timeout mode, a character strobe clears `ctr_ready` at the clock edge where it is sampled, and `irq_req` drops with it.
- R5: A command byte whose bits [7:4] equal 0xA enables timeout mode and clears `ctr_ready`. It also holds the counter stopped until the next character strobe.
- R6: A command byte whose bits [7:4] equal 0xC leaves timeout mode without altering `ctr_ready`. Character strobes after it have no effect.
- R7: While timeout mode is on, command bytes with bits [7:4] equal to 0x8 (start) or 0x9 (stop) are ignored.
- R8: Outside timeout mode, a 0x8 command loads N, clears `ctr_ready` and counts at once. `ctr_ready` then sets at the N-th tick edge after the command edge. A 0x9 command halts the count.
- R9: After reaching zero, the counter stays at zero with `ctr_ready` held, and it does not reload until a strobe or a command.
- R10: A preload of zero counts as 65536 ticks.
- R11: With `ct_tick` low, a pending character strobe is remembered but the counter does not move. Processing resumes at the next tick edge.
- R12: After a synchronous active-low reset, `ctr_ready` and `irq_req` are 0 and timeout mode is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ct_tick | input | 1 | Counter-clock enable, one count per high cycle |
| char_xfer | input | 1 | Pulse: a character reached the holding register |
| preload_hi | input | 8 | Upper byte of the preload value |
| preload_lo | input | 8 | Lower byte of the preload value |
| cmd_wr | input | 1 | Command byte write strobe |
| cmd_data | input | 8 | Command byte; bits [7:4] select the action |
| irq_mask | input | 1 | Interrupt enable for the counter-ready flag |
| ctr_ready | output | 1 | Counter-ready status |
| irq_req | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a character that arrives while the counter clock is paused. The strobe must then be held in the pending flag and acted on only when ticks resume. The stimulus holds `ct_tick` low across a strobe and for many cycles afterward, then releases it and expects the full reload-and-restart delay to be measured from that release. The zero-preload case runs the full 65536-tick span, to show the count neither wraps nor ends early. Back-to-back strobes three cycles apart show that a restart pushes the timeout out.

// File: rtl/rxt_pkg.sv
// Package rxt_pkg
// Shared widths, command nibbles and the counter phase type for the
// receive-driven timeout counter. Assumes 8-bit command bytes.
package rxt_pkg;
    localparam int CMD_W    = 8;
    localparam int NIB_W    = 4;
    localparam logic [NIB_W-1:0] NIB_TMO_ON  = 4'hA;
    localparam logic [NIB_W-1:0] NIB_TMO_OFF = 4'hC;
    localparam logic [NIB_W-1:0] NIB_START   = 4'h8;
    localparam logic [NIB_W-1:0] NIB_STOP    = 4'h9;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,   // halted, holding its value
        PH_ARM  = 2'd1,   // reloaded, waiting one tick before counting
        PH_RUN  = 2'd2    // decrementing once per tick
    } phase_t;
endpackage

// File: rtl/rxt_cmd_decode.sv
// Module rxt_cmd_decode
// Turns a command write into one-cycle action pulses by looking only at
// the upper nibble of the byte. Assumes cmd_wr is high for one cycle per write.
module rxt_cmd_decode
    import rxt_pkg::*;
(
    input  logic             cmd_wr,
    input  logic [CMD_W-1:0] cmd_data,
    output logic             tmo_on_p,
    output logic             tmo_off_p,
    output logic             start_p,
    output logic             stop_p
);
    logic [NIB_W-1:0] nib;

    // Purpose: select the action nibble and decode it.
    always_comb begin
        nib       = cmd_data[CMD_W-1 -: NIB_W];
        tmo_on_p  = cmd_wr && (nib == NIB_TMO_ON);
        tmo_off_p = cmd_wr && (nib == NIB_TMO_OFF);
        start_p   = cmd_wr && (nib == NIB_START);
        stop_p    = cmd_wr && (nib == NIB_STOP);
    end
endmodule

// File: rtl/rxt_mode_ctl.sv
// Module rxt_mode_ctl
// Holds the timeout-mode flag. Assumes the on and off pulses are never
// high together, which holds because they decode different nibbles.
module rxt_mode_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic tmo_on_p,
    input  logic tmo_off_p,
    output logic tmo_mode
);
    // Purpose: set or clear the mode flag from the decoded commands.
    always_ff @(posedge clk) begin
        if (!rst_n)         tmo_mode <= 1'b0;
        else if (tmo_on_p)  tmo_mode <= 1'b1;
        else if (tmo_off_p) tmo_mode <= 1'b0;
    end

    AST_MODE_ON: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_on_p |=> tmo_mode); // R5
    AST_MODE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_off_p |=> !tmo_mode); // R6
endmodule

// File: rtl/rxt_down_counter.sv
// Module rxt_down_counter
// The counter with its phase, its pending-character flag and the ready flag.
// In timeout mode, character strobes drive reload and restart, and the start
// and stop pulses are ignored. Outside it, start and stop drive the count.
// Assumes ct_tick acts as a clock enable and load_val is already nonzero.
module rxt_down_counter
    import rxt_pkg::*;
#(
    parameter int CNT_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ct_tick,
    input  logic             char_xfer,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tmo_mode,
    input  logic             tmo_on_p,
    input  logic             tmo_off_p,
    input  logic             start_p,
    input  logic             stop_p,
    output logic             ready
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] count;
    phase_t           phase;
    logic             pend;

    // Purpose: advance the phase, count, pending flag and ready flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            phase <= PH_IDLE;
            pend  <= 1'b0;
            ready <= 1'b0;
        end else if (tmo_on_p) begin
            phase <= PH_IDLE;
            pend  <= 1'b0;
            ready <= 1'b0;
        end else if (tmo_off_p) begin
            phase <= PH_IDLE;
            pend  <= 1'b0;
        end else if (tmo_mode) begin
            if (char_xfer) ready <= 1'b0;
            if (ct_tick && (char_xfer || pend)) begin
                count <= load_val;
                phase <= PH_ARM;
                pend  <= 1'b0;
            end else begin
                if (char_xfer) pend <= 1'b1;
                if (ct_tick) begin
                    if (phase == PH_ARM) begin
                        phase <= PH_RUN;
                    end else if (phase == PH_RUN) begin
                        count <= count - ONE;
                        if (count == ONE) begin
                            ready <= 1'b1;
                            phase <= PH_IDLE;
                        end
                    end
                end
            end
        end else begin
            if (start_p) begin
                count <= load_val;
                phase <= PH_RUN;
                ready <= 1'b0;
            end else if (stop_p) begin
                phase <= PH_IDLE;
            end else if (ct_tick && phase == PH_RUN) begin
                count <= count - ONE;
                if (count == ONE) begin
                    ready <= 1'b1;
                    phase <= PH_IDLE;
                end
            end
        end
    end

    AST_STROBE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_mode && char_xfer && !tmo_off_p) |=> !ready); // R4
    AST_ENABLE_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_on_p |=> (!ready && phase == PH_IDLE)); // R5
    AST_READY_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> (count == '0)); // R2
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_RUN) |-> (count != '0)); // R9
    AST_ZERO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE && !char_xfer && !pend && !start_p) |=> $stable(count)); // R9
    AST_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_mode && (start_p || stop_p) && phase == PH_IDLE && !char_xfer
         && !pend && !tmo_on_p && !tmo_off_p) |=> (phase == PH_IDLE)); // R7
endmodule

// File: rtl/rx_char_timer.sv
// Module rx_char_timer
// Top of the receive-driven timeout counter. Builds the preload from its two
// bytes (zero means the full 2^PRE_W span), decodes commands, keeps the mode
// and drives the ready flag and the masked interrupt request.
// Assumes all inputs are synchronous to clk.
module rx_char_timer
    import rxt_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ct_tick,
    input  logic              char_xfer,
    input  logic [BYTE_W-1:0] preload_hi,
    input  logic [BYTE_W-1:0] preload_lo,
    input  logic              cmd_wr,
    input  logic [CMD_W-1:0]  cmd_data,
    input  logic              irq_mask,
    output logic              ctr_ready,
    output logic              irq_req
);
    localparam int PRE_W = 2 * BYTE_W;
    localparam int CNT_W = PRE_W + 1;

    logic [PRE_W-1:0] pre_raw;
    logic [CNT_W-1:0] load_val;
    logic tmo_on_p, tmo_off_p, start_p, stop_p, tmo_mode;

    // Purpose: join the bytes and map a zero preload onto the full span.
    always_comb begin
        pre_raw  = {preload_hi, preload_lo};
        load_val = (pre_raw == '0) ? (CNT_W'(1) << PRE_W) : {1'b0, pre_raw};
    end

    rxt_cmd_decode u_dec (
        .cmd_wr    (cmd_wr),
        .cmd_data  (cmd_data),
        .tmo_on_p  (tmo_on_p),
        .tmo_off_p (tmo_off_p),
        .start_p   (start_p),
        .stop_p    (stop_p)
    );

    rxt_mode_ctl u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .tmo_on_p  (tmo_on_p),
        .tmo_off_p (tmo_off_p),
        .tmo_mode  (tmo_mode)
    );

    rxt_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .ct_tick   (ct_tick),
        .char_xfer (char_xfer),
        .load_val  (load_val),
        .tmo_mode  (tmo_mode),
        .tmo_on_p  (tmo_on_p),
        .tmo_off_p (tmo_off_p),
        .start_p   (start_p),
        .stop_p    (stop_p),
        .ready     (ctr_ready)
    );

    // Purpose: gate the ready flag with the mask to form the request.
    always_comb irq_req = ctr_ready & irq_mask;

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!ctr_ready && !tmo_mode)); // R12
endmodule

// File: tb/tb_rx_char_timer.sv
module tb_rx_char_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ct_tick = 1'b1;
    logic       char_xfer = 1'b0;
    logic [7:0] preload_hi = 8'h00;
    logic [7:0] preload_lo = 8'd5;
    logic       cmd_wr = 1'b0;
    logic [7:0] cmd_data = 8'h00;
    logic       irq_mask = 1'b1;
    logic       ctr_ready, irq_req;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        int    at;
        bit    rdy;
        bit    irq;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;   // 250 MHz
    always @(posedge clk) cyc <= cyc + 1;

    rx_char_timer dut (
        .clk(clk), .rst_n(rst_n), .ct_tick(ct_tick), .char_xfer(char_xfer),
        .preload_hi(preload_hi), .preload_lo(preload_lo), .cmd_wr(cmd_wr),
        .cmd_data(cmd_data), .irq_mask(irq_mask),
        .ctr_ready(ctr_ready), .irq_req(irq_req)
    );

    // Monitor: pops expectations due this cycle and compares them.
    always @(negedge clk) begin
        #1;
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            exp_t e;
            e = sb.pop_front();
            total++;
            if (e.at < cyc) begin
                bad++;
                $display("FAIL %s: missed sample cycle %0d (now %0d)", e.tag, e.at, cyc);
            end else if (ctr_ready !== e.rdy || irq_req !== e.irq) begin
                bad++;
                $display("FAIL %s: cyc %0d ready=%0b irq=%0b expected ready=%0b irq=%0b",
                         e.tag, cyc, ctr_ready, irq_req, e.rdy, e.irq);
            end
        end
    end

    task automatic expect_at(int at, bit rdy, string tag);
        exp_t e;
        e.at = at; e.rdy = rdy; e.irq = rdy & irq_mask; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic drain();
        while (sb.size() > 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_char();
        char_xfer = 1'b1;
        @(negedge clk);
        char_xfer = 1'b0;
    endtask

    task automatic command(logic [7:0] b);
        cmd_wr = 1'b1; cmd_data = b;
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    initial begin
        int c0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        expect_at(cyc + 1, 1'b0, "R12 reset state");
        drain();

        // R5 / R1 / R2 / R3: enable, then one strobe with N=5
        command(8'hA0);
        c0 = cyc;
        expect_at(c0 + 6, 1'b0, "R1 not yet at zero");
        expect_at(c0 + 7, 1'b1, "R2 R3 ready and irq after reload+restart");
        pulse_char();
        drain();

        // R9: holds at zero
        expect_at(cyc + 30, 1'b1, "R9 ready held, no wrap");
        drain();

        // R4: strobe clears ready immediately, then times out again
        c0 = cyc;
        expect_at(c0 + 1, 1'b0, "R4 strobe clears ready");
        expect_at(c0 + 7, 1'b1, "R1 timeout after restart");
        pulse_char();
        drain();

        // R3: mask off suppresses the request
        irq_mask = 1'b0;
        expect_at(cyc + 1, 1'b1, "R3 masked irq low");
        drain();
        irq_mask = 1'b1;

        // R5: enable clears ready and holds the counter stopped
        c0 = cyc;
        expect_at(c0 + 1, 1'b0, "R5 enable clears ready");
        expect_at(c0 + 40, 1'b0, "R5 counter stays stopped");
        command(8'hA0);
        drain();

        // R1: a second strobe three cycles later restarts the count
        c0 = cyc;
        expect_at(c0 + 7, 1'b0, "R1 retrigger delays timeout");
        expect_at(c0 + 9, 1'b0, "R1 retrigger still counting");
        expect_at(c0 + 10, 1'b1, "R1 timeout from second strobe");
        pulse_char();
        @(negedge clk); @(negedge clk);
        pulse_char();
        drain();

        // R7: start command ignored in timeout mode
        command(8'hA0);
        c0 = cyc;
        expect_at(c0 + 20, 1'b0, "R7 start ignored in timeout mode");
        command(8'h80);
        drain();

        // R11: strobe while ticks paused is remembered
        ct_tick = 1'b0;
        c0 = cyc;
        expect_at(c0 + 30, 1'b0, "R11 no progress without ticks");
        pulse_char();
        drain();
        ct_tick = 1'b1;
        c0 = cyc;
        expect_at(c0 + 6, 1'b0, "R11 pending strobe counts from tick resume");
        expect_at(c0 + 7, 1'b1, "R11 timeout after tick resume");
        drain();

        // R6: disable keeps ready, later strobes have no effect
        command(8'hC0);
        c0 = cyc;
        expect_at(c0 + 20, 1'b1, "R6 strobe ignored after disable");
        pulse_char();
        drain();

        // R8: plain start/stop outside timeout mode
        c0 = cyc;
        expect_at(c0 + 1, 1'b0, "R8 start clears ready");
        expect_at(c0 + 5, 1'b0, "R8 still counting");
        expect_at(c0 + 6, 1'b1, "R8 ready after N ticks");
        command(8'h80);
        drain();
        c0 = cyc;
        expect_at(c0 + 30, 1'b0, "R8 stop halts count");
        command(8'h80);
        command(8'h90);
        drain();

        // R10: zero preload spans 65536 ticks
        preload_lo = 8'h00;
        command(8'hA0);
        c0 = cyc;
        expect_at(c0 + 65537, 1'b0, "R10 not done at 65535+2");
        expect_at(c0 + 65538, 1'b1, "R10 done at 65536+2");
        pulse_char();
        drain();

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run hung, actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule